// File: doc/BRIEF.md
# Programmable Chip-Select and Wait-State Decoder

This block sits between a 24-bit address bus and external memory devices. It turns each bus access into one active-low chip select out of four programmable regions, a bus-width indication, and an access-done pulse that arrives after the region's number of wait states. Each region has three byte registers: a base value compared against address bits 23..16, a mask whose set bits are left out of that compare (this sets the region's size in 64 KiB steps), and a control byte that holds an enable, a width choice and a wait count. Accesses that hit no enabled region use a separate fallback control byte and drive no chip select.

Two fixed internal windows, for I/O and for on-chip RAM, always take precedence. An address inside them never drives a chip select, whatever the programmed regions say. Software sets the regions through a byte-wide write port. An access is started with a one-cycle strobe. The decoded select and width are latched at that point and held until the done pulse ends.

Top module: `cs_wait_decoder`

## Requirements
- R1: After reset, every chip select is high, `acc_done_o` and `bus_wide_o` are low, and all control bytes are zero. An access made with no register written therefore selects nothing and completes with zero waits.
- R2: A region hits when, for every bit k of 0..7 whose mask bit is 0, address bit 16+k equals base bit k. Address bits 15..0 are never compared. Base 01h with mask 00h hits exactly 010000h..01FFFFh.
- R3: Bit 7 of a region's control byte is its enable. A region with this bit at 0 never asserts its chip select.
- R4: When several enabled regions hit, only the lowest-numbered one asserts its chip select, and its width and wait count are used.
- R5: Addresses from 000000h to 002FFFh (I/O 000000h..000FFFh, RAM 001000h..002FFFh) assert no chip select, use zero wait states, and report 16-bit width, even when a region hits.
- R6: Control bits 2..0 give the wait count W. If the start strobe is sampled in cycle 0, `acc_done_o` is high in exactly cycle 1+W and for that one cycle only.
- R7: Control bit 4 selects width (1 = 16-bit). It is latched to `bus_wide_o` when the access starts and is held until the next access starts.
- R8: An access outside the internal windows that hits no enabled region asserts no chip select and takes its width (bit 4) and wait count (bits 2..0) from the fallback control byte.
- R9: A chip select goes low in cycle 1 after the start, stays low and unchanged through the done cycle, and is high again in the cycle after. At most one chip select is ever low. A start strobe given while an access is in progress is ignored.
- R10: Register address {idx[1:0], fld[1:0]} selects region idx. fld 0 is the base, fld 1 the mask and fld 2 the control byte. Address 3 (idx 0, fld 3) is the fallback control byte. A write that coincides with a start takes effect only for later accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register address {region index, field} |
| reg_wdata_i | input | 8 | Register write data |
| acc_start_i | input | 1 | Access start strobe |
| acc_addr_i | input | 24 | Access byte address |
| cs_n_o | output | 4 | Active-low chip selects, one per region |
| bus_wide_o | output | 1 | Width of the current or last access (1 = 16-bit) |
| acc_done_o | output | 1 | One-cycle pulse that ends the access |

## Verification
The hardest cases to reach are those where several rules apply to one address at once. These include an internal-window address that an enabled all-masked region also claims, two enabled regions that overlap, and a start strobe that arrives in the middle of a long wait. The stimulus first programs a catch-all region with mask FFh next to a narrow region with mask 00h. It then sends addresses on the internal window limits and inside the overlap, disables regions one at a time, and pulses the start strobe while an access with seven wait states is running. The reference model checks every cycle of each of these accesses.

// File: rtl/cs_dec_pkg.sv
package cs_dec_pkg;
  // control byte layout: bit 7 enable, bit 4 width, bits 2..0 wait count
  localparam int CS_WAIT_W = 3;
  localparam int CTL_EN_BIT = 7;
  localparam int CTL_WIDE_BIT = 4;

  typedef struct packed {
    logic                 wide;
    logic [CS_WAIT_W-1:0] wait_cnt;
  } acc_attr_t;

  typedef struct packed {
    logic [7:0] base;
    logic [7:0] mask;
    logic       en;
    acc_attr_t  attr;
  } region_cfg_t;
endpackage

// File: rtl/cs_regfile.sv
module cs_regfile
  import cs_dec_pkg::*;
#(
  parameter int NUM_RGN = 4,
  localparam int IDX_W = $clog2(NUM_RGN),
  localparam int RA_W  = IDX_W + 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [RA_W-1:0]  addr_i,
  input  logic [7:0]       wdata_i,
  output region_cfg_t      cfg_o [NUM_RGN],
  output acc_attr_t        fb_o
);
  localparam logic [RA_W-1:0] FB_ADDR = RA_W'(3);

  for (genvar g = 0; g < NUM_RGN; g++) begin : g_rgn
    region_cfg_t cfg_q;
    logic        sel;
    assign sel = we_i && (addr_i[RA_W-1:2] == IDX_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cfg_q <= '0;
      end else if (sel) begin
        case (addr_i[1:0])
          2'd0: cfg_q.base <= wdata_i;
          2'd1: cfg_q.mask <= wdata_i;
          2'd2: begin
            cfg_q.en            <= wdata_i[CTL_EN_BIT];
            cfg_q.attr.wide     <= wdata_i[CTL_WIDE_BIT];
            cfg_q.attr.wait_cnt <= wdata_i[CS_WAIT_W-1:0];
          end
          default: ;
        endcase
      end
    end
    assign cfg_o[g] = cfg_q;
  end

  acc_attr_t fb_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fb_q <= '0;
    end else if (we_i && addr_i == FB_ADDR) begin
      fb_q.wide     <= wdata_i[CTL_WIDE_BIT];
      fb_q.wait_cnt <= wdata_i[CS_WAIT_W-1:0];
    end
  end
  assign fb_o = fb_q;
endmodule

// File: rtl/cs_region_match.sv
module cs_region_match
  import cs_dec_pkg::*;
(
  input  region_cfg_t cfg_i,
  input  logic [7:0]  addr_hi_i,
  output logic        hit_o
);
  logic [7:0] diff;
  assign diff  = (addr_hi_i ^ cfg_i.base) & ~cfg_i.mask;
  assign hit_o = cfg_i.en && (diff == 8'h00);
endmodule

// File: rtl/cs_prio_sel.sv
module cs_prio_sel #(
  parameter int NUM_RGN = 4
) (
  input  logic [NUM_RGN-1:0] hit_i,
  output logic [NUM_RGN-1:0] grant_o,
  output logic               any_o
);
  always_comb begin
    grant_o = '0;
    any_o   = 1'b0;
    for (int i = 0; i < NUM_RGN; i++) begin
      if (hit_i[i] && !any_o) begin
        grant_o[i] = 1'b1;
        any_o      = 1'b1;
      end
    end
  end
endmodule

// File: rtl/cs_wait_timer.sv
module cs_wait_timer #(
  parameter int WAIT_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [WAIT_W-1:0] wait_i,
  output logic              busy_o,
  output logic              done_o
);
  logic [WAIT_W-1:0] cnt_q;
  logic              busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end else if (load_i) begin
      busy_q <= 1'b1;
      cnt_q  <= wait_i;
    end
  end

  assign busy_o = busy_q;
  assign done_o = busy_q && (cnt_q == '0);
endmodule

// File: rtl/cs_wait_decoder.sv
module cs_wait_decoder
  import cs_dec_pkg::*;
#(
  parameter int          ADDR_W  = 24,
  parameter int          NUM_RGN = 4,
  parameter int unsigned INT_END = 32'h0000_3000,
  localparam int IDX_W  = $clog2(NUM_RGN),
  localparam int RA_W   = IDX_W + 2,
  localparam int HI_LSB = ADDR_W - 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               reg_we_i,
  input  logic [RA_W-1:0]    reg_addr_i,
  input  logic [7:0]         reg_wdata_i,
  input  logic               acc_start_i,
  input  logic [ADDR_W-1:0]  acc_addr_i,
  output logic [NUM_RGN-1:0] cs_n_o,
  output logic               bus_wide_o,
  output logic               acc_done_o
);
  region_cfg_t        cfg [NUM_RGN];
  acc_attr_t          fb;
  logic [NUM_RGN-1:0] hit, grant;
  logic               any_hit, internal, take, busy_q, done;
  acc_attr_t          nxt_attr;
  logic [NUM_RGN-1:0] nxt_sel, sel_q;
  logic               wide_q;

  cs_regfile #(.NUM_RGN(NUM_RGN)) i_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .cfg_o(cfg), .fb_o(fb)
  );

  for (genvar g = 0; g < NUM_RGN; g++) begin : g_match
    cs_region_match i_match (
      .cfg_i(cfg[g]), .addr_hi_i(acc_addr_i[ADDR_W-1:HI_LSB]), .hit_o(hit[g])
    );
  end

  cs_prio_sel #(.NUM_RGN(NUM_RGN)) i_prio (
    .hit_i(hit), .grant_o(grant), .any_o(any_hit)
  );

  assign internal = acc_addr_i < ADDR_W'(INT_END);
  assign take     = acc_start_i && !busy_q;

  always_comb begin
    nxt_attr = fb;
    nxt_sel  = grant;
    for (int i = 0; i < NUM_RGN; i++) begin
      if (grant[i]) nxt_attr = cfg[i].attr;
    end
    if (internal) begin
      nxt_sel           = '0;
      nxt_attr.wide     = 1'b1;
      nxt_attr.wait_cnt = '0;
    end
  end

  cs_wait_timer #(.WAIT_W(CS_WAIT_W)) i_timer (
    .clk_i, .rst_ni,
    .load_i(take), .wait_i(nxt_attr.wait_cnt),
    .busy_o(busy_q), .done_o(done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q  <= '0;
      wide_q <= 1'b0;
    end else if (take) begin
      sel_q  <= nxt_sel;
      wide_q <= nxt_attr.wide;
    end else if (done) begin
      sel_q  <= '0;
    end
  end

  assign cs_n_o     = ~sel_q;
  assign bus_wide_o = wide_q;
  assign acc_done_o = done;
endmodule

// File: rtl/cs_wait_decoder_chk.sv
module cs_wait_decoder_chk #(
  parameter int          ADDR_W  = 24,
  parameter int          NUM_RGN = 4,
  parameter int unsigned INT_END = 32'h0000_3000
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               acc_start_i,
  input logic [ADDR_W-1:0]  acc_addr_i,
  input logic [NUM_RGN-1:0] cs_n_o,
  input logic               acc_done_o,
  input logic               busy_q
);
  // R1
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      reset_idle_chk: assert (&cs_n_o && !acc_done_o) else $error("reset state");
    end
  end

  // R9
  single_cs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~cs_n_o));

  // R5
  internal_no_cs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_start_i && !busy_q && acc_addr_i < ADDR_W'(INT_END)) |=> &cs_n_o);

  // R6
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_done_o |=> !acc_done_o);

  // R9
  cs_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!acc_done_o && !(&cs_n_o)) |=> $stable(cs_n_o));

  // R9
  cs_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_done_o |=> &cs_n_o);
endmodule

bind cs_wait_decoder cs_wait_decoder_chk #(
  .ADDR_W(ADDR_W), .NUM_RGN(NUM_RGN), .INT_END(INT_END)
) i_chk (.*);

// File: tb/test_cs_wait_decoder.sv
module test_cs_wait_decoder;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [3:0]  reg_addr_i = '0;
  logic [7:0]  reg_wdata_i = '0;
  logic        acc_start_i = 1'b0;
  logic [23:0] acc_addr_i = '0;
  logic [3:0]  cs_n_o;
  logic        bus_wide_o;
  logic        acc_done_o;

  cs_wait_decoder i_cs_wait_decoder (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  int n_tests = 0, n_fail = 0;
  bit finished = 0;
  string cur_req = "R1";

  // reference model state
  bit [7:0] m_base [4], m_mask [4], m_ctrl [4], m_fb;
  bit       m_busy, m_wide;
  int       m_rem, m_sel;

  task automatic model_reset();
    for (int i = 0; i < 4; i++) begin m_base[i] = 0; m_mask[i] = 0; m_ctrl[i] = 0; end
    m_fb = 0; m_busy = 0; m_wide = 0; m_rem = 0; m_sel = -1;
  endtask

  task automatic check(string req, string what, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic compare();
    bit [3:0] e_cs = 4'hF;
    if (m_busy && m_sel >= 0) e_cs[m_sel] = 1'b0;
    check(cur_req, "cs_n", cs_n_o, e_cs);
    check(cur_req, "done", acc_done_o, m_busy && m_rem == 0);
    check(cur_req, "wide", bus_wide_o, m_wide);
  endtask

  task automatic model_step(bit we, bit [3:0] wa, bit [7:0] wd, bit st, bit [23:0] a);
    if (m_busy) begin
      if (m_rem == 0) begin m_busy = 0; m_sel = -1; end
      else m_rem--;
    end else if (st) begin
      int sel = -1;
      bit [7:0] c;
      if (a < 24'h003000) begin
        m_sel = -1; m_wide = 1; m_rem = 0;
      end else begin
        for (int r = 0; r < 4; r++)
          if (sel < 0 && m_ctrl[r][7] && (((a[23:16] ^ m_base[r]) & ~m_mask[r]) == 0)) sel = r;
        c = (sel >= 0) ? m_ctrl[sel] : m_fb;
        m_sel = sel; m_wide = c[4]; m_rem = c[2:0];
      end
      m_busy = 1;
    end
    if (we) begin
      if (wa == 4'd3) m_fb = wd;
      else case (wa[1:0])
        2'd0: m_base[wa[3:2]] = wd;
        2'd1: m_mask[wa[3:2]] = wd;
        2'd2: m_ctrl[wa[3:2]] = wd;
        default: ;
      endcase
    end
  endtask

  // called at a negedge; returns at the next negedge after comparing
  task automatic cycle(bit we, bit [3:0] wa, bit [7:0] wd, bit st, bit [23:0] a);
    reg_we_i = we; reg_addr_i = wa; reg_wdata_i = wd; acc_start_i = st; acc_addr_i = a;
    @(posedge clk_i);
    model_step(we, wa, wd, st, a);
    @(negedge clk_i);
    reg_we_i = 0; acc_start_i = 0;
    compare();
  endtask

  task automatic wr(bit [3:0] wa, bit [7:0] wd);
    cycle(1, wa, wd, 0, '0);
  endtask

  task automatic access(bit [23:0] a);
    cycle(0, '0, '0, 1, a);
    while (m_busy) cycle(0, '0, '0, 0, '0);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk_i);
    cur_req = "R1";
    check("R1", "reset cs_n", cs_n_o, 4'hF);
    check("R1", "reset done", acc_done_o, 0);
    check("R1", "reset wide", bus_wide_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    access(24'h010000);
    access(24'hFF0000);

    // R10 register map, R2 compare and mask
    cur_req = "R10";
    wr(4'd0, 8'h01); wr(4'd1, 8'h00); wr(4'd2, 8'h92);
    cur_req = "R2";
    access(24'h010000); access(24'h01FFFF); access(24'h020000); access(24'h00FFFF);
    wr(4'd1, 8'h06);
    access(24'h070000); access(24'h080000);
    wr(4'd1, 8'h00);

    // R3 disabled region
    cur_req = "R3";
    wr(4'd4, 8'h40); wr(4'd5, 8'h00); wr(4'd6, 8'h13);
    access(24'h400000);
    wr(4'd6, 8'h83);
    access(24'h400123);

    // R4 priority among overlapping regions
    cur_req = "R4";
    wr(4'd5, 8'hFF); wr(4'd6, 8'h81);
    wr(4'd8, 8'h01); wr(4'd9, 8'h00); wr(4'd10, 8'h95);
    access(24'h010000); access(24'h500000);
    wr(4'd2, 8'h12);
    access(24'h010000);
    wr(4'd6, 8'h01);
    access(24'h01ABCD);

    // R5 internal windows beat a catch-all region
    cur_req = "R5";
    wr(4'd6, 8'h87); wr(4'd0, 8'h00); wr(4'd1, 8'hFF); wr(4'd2, 8'h84);
    access(24'h000000); access(24'h000FFF); access(24'h001000);
    access(24'h002FFF); access(24'h003000);

    // R6 wait counts 0 and 7
    cur_req = "R6";
    wr(4'd2, 8'h80); access(24'h123456);
    wr(4'd2, 8'h87); access(24'h123456);

    // R8 fallback
    cur_req = "R8";
    wr(4'd2, 8'h00); wr(4'd6, 8'h00); wr(4'd10, 8'h00);
    wr(4'd3, 8'h15); access(24'h900000);
    wr(4'd3, 8'h02); access(24'h900000);

    // R7 width latched and held
    cur_req = "R7";
    wr(4'd3, 8'h10); access(24'hA00000);
    repeat (3) cycle(0, '0, '0, 0, '0);
    wr(4'd3, 8'h00); access(24'hA00000);

    // R9 start ignored while busy; R10 write during start
    cur_req = "R9";
    wr(4'd14, 8'h87); wr(4'd12, 8'hC0); wr(4'd13, 8'h00);
    cycle(0, '0, '0, 1, 24'hC00000);
    cycle(0, '0, '0, 1, 24'h010000);
    cycle(0, '0, '0, 1, 24'h000000);
    while (m_busy) cycle(0, '0, '0, 0, '0);
    cur_req = "R10";
    cycle(1, 4'd14, 8'h80, 1, 24'hC00000);
    while (m_busy) cycle(0, '0, '0, 0, '0);
    access(24'hC00000);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule